// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the meeting point between a host processor and an embedded power-management controller. The host sees a small window of 32-bit registers on a simple register bus. Writing a command word hands a request to the controller. The controller is woken by a one-cycle doorbell that carries the decoded command fields: opcode, sub-opcode and input length. Before it writes the command, the host can load a pair of pointer words and up to four words of input data.

The controller reads the input words by index and places up to four result words in a read buffer. It then raises a completion strobe, which carries an error flag and an 8-bit error code. The host learns of completion in one of two ways. It can poll a busy bit, or it can ask for an interrupt by setting a flag in the command word. It acknowledges that interrupt by writing a one to the pending bit.

A request that arrives while a previous one is still open is dropped. Completion strobes that arrive while nothing is open are also dropped.

Top module: `ctl_mailbox`

## Requirements
- R1: After reset, every readable register reads zero, `hostIrq` is low and `ctlDoorbell` is low.
- R2: A host write to offset 0x00 while not busy sets busy (status bit 0) from the next cycle. It pulses `ctlDoorbell` high for exactly one cycle, also from the next cycle. It presents command bits 7:0 on `ctlOpcode`, bits 15:12 on `ctlSub` and bits 23:16 on `ctlLen`.
- R3: A `ctlDone` pulse while busy has four effects: it clears busy, it copies `ctlErr` into status bit 1, it loads status bits 23:16 with `ctlErrCode` when `ctlErr` is high and with zero otherwise, and it takes effect on the next cycle. A `ctlDone` pulse while idle changes nothing.
- R4: A host write to offset 0x00 while busy is ignored: no doorbell is raised and the presented command fields keep their values.
- R5: When a completion is accepted, status bit 2 and `hostIrq` are set only if bit 8 of the accepted command word was one. Once set, they stay set until acknowledged.
- R6: A host write to offset 0x04 with bit 2 set clears the pending interrupt. A write to 0x04 with bit 2 clear has no effect. If an accepted completion that requests an interrupt falls in the same cycle as the acknowledge, the interrupt stays pending.
- R7: Offsets 0x08 and 0x0C hold the source and destination pointers. The host can read and write both, and they drive `ctlSrcPtr` and `ctlDstPtr`.
- R8: Offsets 0x80, 0x84, 0x88 and 0x8C hold input words 0 to 3. The host can read and write them, and the controller reads word `ctlWbufIdx` on `ctlWbufData`.
- R9: Offsets 0x90, 0x94, 0x98 and 0x9C return result words 0 to 3. The controller writes them through `ctlRbufWe`, `ctlRbufIdx` and `ctlRbufData`. Host writes to these offsets are ignored.
- R10: Host reads at any other offset, including misaligned ones, return zero. Host writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host bus access this cycle |
| hostWr | input | 1 | Access is a write when high |
| hostAddr | input | ADDR_W | Byte offset of the access |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Host read data, valid in the same cycle as the read |
| hostIrq | output | 1 | Completion interrupt, level |
| ctlDoorbell | output | 1 | One-cycle pulse for a new command |
| ctlOpcode | output | 8 | Command opcode |
| ctlSub | output | 4 | Command sub-opcode |
| ctlLen | output | 8 | Input length in bytes |
| ctlSrcPtr | output | DATA_W | Source pointer register |
| ctlDstPtr | output | DATA_W | Destination pointer register |
| ctlWbufIdx | input | log2(BUF_WORDS) | Input word index read by the controller |
| ctlWbufData | output | DATA_W | Selected input word |
| ctlRbufWe | input | 1 | Result word write enable |
| ctlRbufIdx | input | log2(BUF_WORDS) | Result word index |
| ctlRbufData | input | DATA_W | Result word data |
| ctlDone | input | 1 | Completion strobe |
| ctlErr | input | 1 | Completion carries an error |
| ctlErrCode | input | CODE_W | Error code on completion |

## Verification
Two functions can fall in the same cycle. A completion strobe for an interrupt-requesting command can arrive in the very cycle that the host writes the acknowledge bit. The bench provokes this by driving `ctlDone` and the status write together at one falling edge. It then judges that status bit 2 and `hostIrq` remain set, and that a later plain acknowledge clears them. A second overlap is a command write against a still-open request. The bench judges that one by the absence of a doorbell and by unchanged opcode fields.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Register offsets: fixed, since host software depends on them
  localparam logic [15:0] OFF_CMD  = 16'h0000;
  localparam logic [15:0] OFF_STS  = 16'h0004;
  localparam logic [15:0] OFF_SRC  = 16'h0008;
  localparam logic [15:0] OFF_DST  = 16'h000C;
  localparam logic [15:0] OFF_WBUF = 16'h0080;
  localparam logic [15:0] OFF_RBUF = 16'h0090;

  // Command word field positions
  localparam int OP_W     = 8;
  localparam int IRQ_BIT  = 8;
  localparam int SUB_LSB  = 12;
  localparam int SUB_W    = 4;
  localparam int LEN_LSB  = 16;
  localparam int LEN_W    = 8;

  // Status word field positions
  localparam int STS_BUSY = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_IRQ  = 2;
  localparam int CODE_LSB = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CMD, SEL_STS, SEL_SRC, SEL_DST, SEL_WBUF, SEL_RBUF
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cmdLoad;
    logic srcWe;
    logic dstWe;
    logic wbufWe;
  } strobe_t;

  function automatic regSel_e decodeAddr(input logic [15:0] a, input int unsigned bufBytes);
    if (a == OFF_CMD) return SEL_CMD;
    if (a == OFF_STS) return SEL_STS;
    if (a == OFF_SRC) return SEL_SRC;
    if (a == OFF_DST) return SEL_DST;
    if (a[1:0] == 2'b00 && 32'(a) >= 32'(OFF_WBUF) && 32'(a) < 32'(OFF_WBUF) + bufBytes)
      return SEL_WBUF;
    if (a[1:0] == 2'b00 && 32'(a) >= 32'(OFF_RBUF) && 32'(a) < 32'(OFF_RBUF) + bufBytes)
      return SEL_RBUF;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 8,
  parameter int BUF_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              wdIrqReq,
  input  logic              wdIrqClr,
  input  logic              ctlDone,
  input  logic              ctlErr,
  input  logic [CODE_W-1:0] ctlErrCode,
  output strobe_t           strobe,
  output regSel_e           rdSel,
  output logic [DATA_W-1:0] statusWord,
  output logic              doorbell,
  output logic              irqOut
);
  localparam int unsigned BUF_BYTES = BUF_WORDS * (DATA_W / 8);

  logic              busy, err, irqReq, irqPend;
  logic [CODE_W-1:0] errCode;
  regSel_e           sel;
  logic              wrEn, cmdAccept, doneTake, ackWrite;

  assign sel       = decodeAddr(16'(hostAddr), BUF_BYTES);
  assign wrEn      = hostSel && hostWr;
  assign cmdAccept = wrEn && (sel == SEL_CMD) && !busy;
  assign doneTake  = ctlDone && busy;
  assign ackWrite  = wrEn && (sel == SEL_STS) && wdIrqClr;
  assign rdSel     = (hostSel && !hostWr) ? sel : SEL_NONE;

  always_comb begin
    strobe.cmdLoad = cmdAccept;
    strobe.srcWe   = wrEn && (sel == SEL_SRC);
    strobe.dstWe   = wrEn && (sel == SEL_DST);
    strobe.wbufWe  = wrEn && (sel == SEL_WBUF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; err <= 1'b0; errCode <= '0;
      irqReq <= 1'b0; irqPend <= 1'b0; doorbell <= 1'b0;
    end else begin
      doorbell <= cmdAccept;
      if (cmdAccept) begin
        busy   <= 1'b1;
        irqReq <= wdIrqReq;
      end else if (doneTake) begin
        busy    <= 1'b0;
        err     <= ctlErr;
        errCode <= ctlErr ? ctlErrCode : '0;
      end
      // A new completion wins over a same-cycle acknowledge
      if (doneTake && irqReq) irqPend <= 1'b1;
      else if (ackWrite)      irqPend <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STS_BUSY] = busy;
    statusWord[STS_ERR]  = err;
    statusWord[STS_IRQ]  = irqPend;
    statusWord[CODE_LSB +: CODE_W] = errCode;
  end

  assign irqOut = irqPend;

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_CMD && !busy) |=> (busy && doorbell));
  assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlDone && busy) |=> !busy);
  assert_no_second_bell_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_CMD && busy) |=> !doorbell);
  assert_irq_requested_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> $past(irqReq));
  assert_ack_race_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlDone && busy && irqReq) |=> irqPend);
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  regSel_e           rdSel,
  input  logic              hostRbufWr,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] hostRdata,
  output logic [OP_W-1:0]   opcode,
  output logic [SUB_W-1:0]  subOp,
  output logic [LEN_W-1:0]  lenBytes,
  output logic [DATA_W-1:0] srcPtr,
  output logic [DATA_W-1:0] dstPtr,
  input  logic [IDX_W-1:0]  ctlWbufIdx,
  output logic [DATA_W-1:0] ctlWbufData,
  input  logic              ctlRbufWe,
  input  logic [IDX_W-1:0]  ctlRbufIdx,
  input  logic [DATA_W-1:0] ctlRbufData
);
  logic [BUF_WORDS-1:0][DATA_W-1:0] wbuf, rbuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode <= '0; subOp <= '0; lenBytes <= '0;
      srcPtr <= '0; dstPtr <= '0;
    end else begin
      if (strobe.cmdLoad) begin
        opcode   <= hostWdata[OP_W-1:0];
        subOp    <= hostWdata[SUB_LSB +: SUB_W];
        lenBytes <= hostWdata[LEN_LSB +: LEN_W];
      end
      if (strobe.srcWe) srcPtr <= hostWdata;
      if (strobe.dstWe) dstPtr <= hostWdata;
    end
  end

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wbuf[w] <= '0;
        rbuf[w] <= '0;
      end else begin
        if (strobe.wbufWe && wordIdx == IDX_W'(w)) wbuf[w] <= hostWdata;
        if (ctlRbufWe && ctlRbufIdx == IDX_W'(w))  rbuf[w] <= ctlRbufData;
      end
    end
  end

  assign ctlWbufData = wbuf[ctlWbufIdx];

  always_comb begin
    unique case (rdSel)
      SEL_CMD:  begin
        hostRdata = '0;
        hostRdata[OP_W-1:0] = opcode;
        hostRdata[SUB_LSB +: SUB_W] = subOp;
        hostRdata[LEN_LSB +: LEN_W] = lenBytes;
      end
      SEL_STS:  hostRdata = statusWord;
      SEL_SRC:  hostRdata = srcPtr;
      SEL_DST:  hostRdata = dstPtr;
      SEL_WBUF: hostRdata = wbuf[wordIdx];
      SEL_RBUF: hostRdata = rbuf[wordIdx];
      default:  hostRdata = '0;
    endcase
  end

  assert_rbuf_host_ro_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostRbufWr && !ctlRbufWe) |=> $stable(rbuf));
endmodule

// File: rtl/ctl_mailbox.sv
module ctl_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 8,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostIrq,
  output logic              ctlDoorbell,
  output logic [OP_W-1:0]   ctlOpcode,
  output logic [SUB_W-1:0]  ctlSub,
  output logic [LEN_W-1:0]  ctlLen,
  output logic [DATA_W-1:0] ctlSrcPtr,
  output logic [DATA_W-1:0] ctlDstPtr,
  input  logic [IDX_W-1:0]  ctlWbufIdx,
  output logic [DATA_W-1:0] ctlWbufData,
  input  logic              ctlRbufWe,
  input  logic [IDX_W-1:0]  ctlRbufIdx,
  input  logic [DATA_W-1:0] ctlRbufData,
  input  logic              ctlDone,
  input  logic              ctlErr,
  input  logic [CODE_W-1:0] ctlErrCode
);
  localparam int unsigned BUF_BYTES = BUF_WORDS * (DATA_W / 8);

  strobe_t           strobe;
  regSel_e           rdSel;
  logic [DATA_W-1:0] statusWord;
  logic              hostRbufWr;

  assign hostRbufWr = hostSel && hostWr &&
                      (decodeAddr(16'(hostAddr), BUF_BYTES) == SEL_RBUF);

  mbox_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .wdIrqReq(hostWdata[IRQ_BIT]), .wdIrqClr(hostWdata[STS_IRQ]),
    .ctlDone(ctlDone), .ctlErr(ctlErr), .ctlErrCode(ctlErrCode),
    .strobe(strobe), .rdSel(rdSel), .statusWord(statusWord),
    .doorbell(ctlDoorbell), .irqOut(hostIrq)
  );

  mbox_dpath #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .hostRbufWr(hostRbufWr),
    .wordIdx(hostAddr[2 +: IDX_W]), .hostWdata(hostWdata), .statusWord(statusWord),
    .hostRdata(hostRdata), .opcode(ctlOpcode), .subOp(ctlSub), .lenBytes(ctlLen),
    .srcPtr(ctlSrcPtr), .dstPtr(ctlDstPtr),
    .ctlWbufIdx(ctlWbufIdx), .ctlWbufData(ctlWbufData),
    .ctlRbufWe(ctlRbufWe), .ctlRbufIdx(ctlRbufIdx), .ctlRbufData(ctlRbufData)
  );
endmodule

// File: tb/ctl_mailbox_bench.sv
`timescale 1ns/1ps
module ctl_mailbox_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 0, hostWr = 0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic        hostIrq, ctlDoorbell;
  logic [7:0]  ctlOpcode, ctlLen;
  logic [3:0]  ctlSub;
  logic [31:0] ctlSrcPtr, ctlDstPtr, ctlWbufData;
  logic [1:0]  ctlWbufIdx = '0, ctlRbufIdx = '0;
  logic        ctlRbufWe = 0;
  logic [31:0] ctlRbufData = '0;
  logic        ctlDone = 0, ctlErr = 0;
  logic [7:0]  ctlErrCode = '0;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  ctl_mailbox u_ctl_mailbox (.*);

  // {command word, error flag byte, error code}
  localparam logic [47:0] VEC [4] = '{
    {32'h0000_0105, 8'h00, 8'h00},
    {32'h0008_3022, 8'h01, 8'h05},
    {32'h0010_F1FF, 8'h01, 8'h07},
    {32'h0004_0010, 8'h00, 8'h33}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 0; hostWr = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hostSel = 1; hostWr = 0; hostAddr = a;
    #1 d = hostRdata;
    hostSel = 0;
  endtask

  task automatic finishCmd(input logic e, input logic [7:0] code);
    @(negedge clk);
    ctlDone = 1; ctlErr = e; ctlErrCode = code;
    @(negedge clk);
    ctlDone = 0; ctlErr = 0; ctlErrCode = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    busRead(8'h04, rd); chk("R1 status", rd, 32'h0);
    chk("R1 irq", {31'b0, hostIrq}, 32'h0);
    chk("R1 doorbell", {31'b0, ctlDoorbell}, 32'h0);
    busRead(8'h08, rd); chk("R1 srcptr", rd, 32'h0);

    // Vector table: R2, R3, R5, R6
    for (int i = 0; i < 4; i++) begin
      logic [31:0] cw, expSts;
      logic        e;
      logic [7:0]  code;
      cw = VEC[i][47:16]; e = VEC[i][8]; code = VEC[i][7:0];
      busWrite(8'h00, cw);
      chk("R2 doorbell", {31'b0, ctlDoorbell}, 32'h1);
      chk("R2 opcode", {24'b0, ctlOpcode}, {24'b0, cw[7:0]});
      chk("R2 sub", {28'b0, ctlSub}, {28'b0, cw[15:12]});
      chk("R2 len", {24'b0, ctlLen}, {24'b0, cw[23:16]});
      busRead(8'h04, rd); chk("R2 busy", {31'b0, rd[0]}, 32'h1);
      chk("R2 single pulse", {31'b0, ctlDoorbell}, 32'h0);
      finishCmd(e, code);
      expSts = {8'h00, (e ? code : 8'h00), 13'b0, cw[8], e, 1'b0};
      busRead(8'h04, rd); chk("R3 R5 status", rd, expSts);
      chk("R5 irq", {31'b0, hostIrq}, {31'b0, cw[8]});
      if (cw[8]) begin
        busWrite(8'h04, 32'h4);
        chk("R6 ack", {31'b0, hostIrq}, 32'h0);
      end
    end

    // R3 completion while idle ignored (previous status is zero)
    finishCmd(1'b1, 8'h09);
    busRead(8'h04, rd); chk("R3 idle done", rd, 32'h0);

    // R4 command while busy ignored
    busWrite(8'h00, 32'h0000_0107);
    busWrite(8'h00, 32'h0000_0033);
    chk("R4 no doorbell", {31'b0, ctlDoorbell}, 32'h0);
    chk("R4 opcode held", {24'b0, ctlOpcode}, 32'h07);
    finishCmd(1'b0, 8'h00);
    chk("R4 first irq kept", {31'b0, hostIrq}, 32'h1);
    busWrite(8'h04, 32'h4);

    // R6 acknowledge racing a completion
    busWrite(8'h00, 32'h0000_0111);
    @(negedge clk);
    ctlDone = 1; hostSel = 1; hostWr = 1; hostAddr = 8'h04; hostWdata = 32'h4;
    @(negedge clk);
    ctlDone = 0; hostSel = 0; hostWr = 0;
    busRead(8'h04, rd); chk("R6 race pending", rd, 32'h4);
    busWrite(8'h04, 32'h0);
    chk("R6 bit2 clear no effect", {31'b0, hostIrq}, 32'h1);
    busWrite(8'h04, 32'h4);
    chk("R6 clear", {31'b0, hostIrq}, 32'h0);

    // R7 pointers
    busWrite(8'h08, 32'hA5A5_0001);
    busWrite(8'h0C, 32'h5A5A_0002);
    busRead(8'h08, rd); chk("R7 src read", rd, 32'hA5A5_0001);
    busRead(8'h0C, rd); chk("R7 dst read", rd, 32'h5A5A_0002);
    chk("R7 src port", ctlSrcPtr, 32'hA5A5_0001);
    chk("R7 dst port", ctlDstPtr, 32'h5A5A_0002);

    // R8 input buffer
    for (int w = 0; w < 4; w++) busWrite(8'h80 + 8'(4 * w), 32'h1111_1111 * (w + 1));
    for (int w = 0; w < 4; w++) begin
      ctlWbufIdx = 2'(w);
      #1 chk("R8 ctl read", ctlWbufData, 32'h1111_1111 * (w + 1));
      busRead(8'h80 + 8'(4 * w), rd); chk("R8 host read", rd, 32'h1111_1111 * (w + 1));
    end

    // R9 result buffer
    @(negedge clk);
    ctlRbufWe = 1; ctlRbufIdx = 2'd2; ctlRbufData = 32'hDEAD_BEEF;
    @(negedge clk);
    ctlRbufWe = 0;
    busRead(8'h98, rd); chk("R9 host read", rd, 32'hDEAD_BEEF);
    busWrite(8'h98, 32'h0);
    busRead(8'h98, rd); chk("R9 host write ignored", rd, 32'hDEAD_BEEF);
    busRead(8'h94, rd); chk("R9 other word", rd, 32'h0);

    // R10 unmapped offsets
    busWrite(8'h40, 32'hFFFF_FFFF);
    busWrite(8'h82, 32'hFFFF_FFFF);
    busRead(8'h40, rd); chk("R10 read zero", rd, 32'h0);
    busRead(8'h82, rd); chk("R10 misaligned zero", rd, 32'h0);
    busRead(8'h80, rd); chk("R10 wbuf untouched", rd, 32'h1111_1111);
    busRead(8'h04, rd); chk("R10 status untouched", rd, 32'h0);

    summary();
  end
endmodule